// File: doc/BRIEF.md
# Rectangle Blit Address Walker

This block produces the destination address sequence for a rectangular block transfer. Software loads a start coordinate and a rectangle size through a small byte-enabled register port. Writing the top byte of the coordinate word converts the X/Y pair into a linear byte address. Writing the top byte of the size word launches a walk over the rectangle.

During a walk the block issues one linear address per accepted handshake on a valid/ready stream. It moves left to right along a row, then on to the next row. The line pitch and the bytes per pixel are static configuration inputs. The memory traffic itself belongs to a downstream consumer.

A launch with a zero width or zero height raises an error pulse and does nothing else. Register writes made during a walk are dropped, and a sticky flag records that this happened.

Top module: `blit_addr_walker`

## Requirements
- R1: Register word 0 holds the size: the width in pixels in bits 11:0 and the height in lines in bits 27:16. A write to word 0 with byte enable 3 set, and with both merged fields nonzero, starts a walk. `busy` and `out_valid` are high in the cycle after that write.
- R2: If the merged width or height of a launching write is zero, `err_size` is high for exactly the next cycle and no walk starts.
- R3: Register word 1 holds the coordinate: X in bits 10:0 and Y in bits 26:16, both unsigned. A write to it with byte enable 3 set makes `dst_linear` equal Y*pitch + X*bpp, using the merged fields, in the next cycle. A write that leaves byte 3 clear only updates the stored bytes and leaves `dst_linear` unchanged.
- R4: Register word 2 behaves exactly like word 1. Word 3 has no effect.
- R5: A walk starts at `dst_linear` and emits width*height addresses, one row at a time. Within a row the address grows by bpp. At the end of a row it grows by bpp plus (pitch - width*bpp), so row r, column c has address start + r*pitch + c*bpp.
- R6: `out_valid` is high only while `busy` is high. While `out_valid` is high and `out_ready` is low, `out_addr` holds its value.
- R7: In the cycle after the last address is accepted, `done` is high for one cycle and `busy` is low.
- R8: Register writes made while `busy` is high change no register. They set `wr_ignored`, which stays high until reset.
- R9: The size register keeps its value after a walk. A write of only byte 3 that leaves the height unchanged repeats a walk of the same size.
- R10: After reset, `busy`, `out_valid`, `done`, `err_size` and `wr_ignored` are low, and `dst_linear` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register word select: 0 size, 1 coordinate, 2 coordinate alias |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte enables for the write |
| pitch | input | 16 | Line pitch in bytes (static) |
| bpp | input | 3 | Bytes per pixel, 1 to 4 (static) |
| dst_linear | output | 32 | Converted linear start address |
| out_valid | output | 1 | Address stream valid |
| out_ready | input | 1 | Address stream ready |
| out_addr | output | 32 | Current pixel address |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse after the last address |
| err_size | output | 1 | One-cycle pulse on a zero-size launch |
| wr_ignored | output | 1 | Sticky flag for writes dropped while busy |

## Verification
Each register write takes effect at one clock edge, so `dst_linear`, `busy`, `out_valid` and `err_size` are due one cycle after the write. The bench drives on the falling edge and checks them on the very next falling edge. A stream address is compared at the falling edge before the rising edge that accepts it, against start + r*pitch + c*bpp. `done` is checked on the falling edge right after the last acceptance, and again one cycle later to confirm it has dropped. Ready is toggled with several masks so that stalls fall both inside rows and at row ends.

// File: rtl/blitw_pkg.sv
package blitw_pkg;
  localparam int DIM_W   = 12;
  localparam int CRD_W   = 11;
  localparam int PITCH_W = 16;
  localparam int BPP_W   = 3;
  localparam int ADDR_W  = 32;
  localparam int WORD_W  = 32;
  localparam int BE_W    = WORD_W / 8;

  // field positions that the register decode relies on
  localparam int W_LSB = 0;
  localparam int H_LSB = 16;
  localparam int X_LSB = 0;
  localparam int Y_LSB = 16;

  typedef enum logic [1:0] {
    SEL_SIZE    = 2'd0,
    SEL_COORD   = 2'd1,
    SEL_COORD_B = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;

  function automatic logic [WORD_W-1:0] merge_bytes(
    input logic [WORD_W-1:0] old_w,
    input logic [WORD_W-1:0] new_w,
    input logic [BE_W-1:0]   be
  );
    logic [WORD_W-1:0] r;
    for (int i = 0; i < BE_W; i++)
      r[i*8 +: 8] = be[i] ? new_w[i*8 +: 8] : old_w[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] xy_to_lin(
    input logic [CRD_W-1:0]   x,
    input logic [CRD_W-1:0]   y,
    input logic [PITCH_W-1:0] pit,
    input logic [BPP_W-1:0]   bytes
  );
    return ADDR_W'(y) * ADDR_W'(pit) + ADDR_W'(x) * ADDR_W'(bytes);
  endfunction

  function automatic logic [ADDR_W-1:0] row_step(
    input logic [PITCH_W-1:0] pit,
    input logic [BPP_W-1:0]   bytes,
    input logic [DIM_W-1:0]   width
  );
    return ADDR_W'(pit) - ADDR_W'(width) * ADDR_W'(bytes);
  endfunction
endpackage

// File: rtl/blitw_regs.sv
module blitw_regs
  import blitw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         sel,
  input  logic [WORD_W-1:0]  wdata,
  input  logic [BE_W-1:0]    be,
  input  logic               busy,
  input  logic [PITCH_W-1:0] pitch,
  input  logic [BPP_W-1:0]   bpp,
  output logic [DIM_W-1:0]   start_w,
  output logic [DIM_W-1:0]   start_h,
  output logic [ADDR_W-1:0]  dst_lin,
  output logic               start_evt,
  output logic               convert_evt,
  output logic               err_size,
  output logic               wr_ignored
);
  logic [DIM_W-1:0] w_q, h_q;
  logic [CRD_W-1:0] x_q, y_q;
  logic [WORD_W-1:0] size_old, coord_old, size_nx, coord_nx;
  logic wr_ok, hit_size, hit_coord, kick, dims_ok;
  logic [DIM_W-1:0] w_nx, h_nx;
  logic [CRD_W-1:0] x_nx, y_nx;
  logic unused_bits;

  assign wr_ok     = wr_en && !busy;
  assign hit_size  = wr_ok && (reg_sel_e'(sel) == SEL_SIZE);
  assign hit_coord = wr_ok && ((reg_sel_e'(sel) == SEL_COORD) ||
                               (reg_sel_e'(sel) == SEL_COORD_B));

  always_comb begin
    size_old = '0;
    size_old[W_LSB +: DIM_W] = w_q;
    size_old[H_LSB +: DIM_W] = h_q;
    coord_old = '0;
    coord_old[X_LSB +: CRD_W] = x_q;
    coord_old[Y_LSB +: CRD_W] = y_q;
  end

  assign size_nx  = merge_bytes(size_old, wdata, be);
  assign coord_nx = merge_bytes(coord_old, wdata, be);
  assign w_nx = size_nx[W_LSB +: DIM_W];
  assign h_nx = size_nx[H_LSB +: DIM_W];
  assign x_nx = coord_nx[X_LSB +: CRD_W];
  assign y_nx = coord_nx[Y_LSB +: CRD_W];
  assign unused_bits = ^{size_nx[15:12], size_nx[31:28],
                         coord_nx[15:11], coord_nx[31:27]};

  assign kick        = hit_size && be[BE_W-1];
  assign dims_ok     = (w_nx != '0) && (h_nx != '0);
  assign start_evt   = kick && dims_ok;
  assign convert_evt = hit_coord && be[BE_W-1];
  assign start_w     = w_nx;
  assign start_h     = h_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q        <= '0;
      h_q        <= '0;
      x_q        <= '0;
      y_q        <= '0;
      dst_lin    <= '0;
      err_size   <= 1'b0;
      wr_ignored <= 1'b0;
    end else begin
      if (hit_size) begin
        w_q <= w_nx;
        h_q <= h_nx;
      end
      if (hit_coord) begin
        x_q <= x_nx;
        y_q <= y_nx;
      end
      if (convert_evt)
        dst_lin <= xy_to_lin(x_nx, y_nx, pitch, bpp);
      err_size <= kick && !dims_ok;
      if (wr_en && busy)
        wr_ignored <= 1'b1;
    end
  end
endmodule

// File: rtl/blitw_walker.sv
module blitw_walker
  import blitw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [DIM_W-1:0]   start_w,
  input  logic [DIM_W-1:0]   start_h,
  input  logic [ADDR_W-1:0]  base,
  input  logic [PITCH_W-1:0] pitch,
  input  logic [BPP_W-1:0]   bpp,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [ADDR_W-1:0]  out_addr,
  output logic               busy,
  output logic               done,
  output logic               accept_evt,
  output logic               last_evt
);
  logic              active;
  logic [DIM_W-1:0]  col, row, wq, hq;
  logic [ADDR_W-1:0] addr_q, step_q, pix_q;
  logic              row_end, last_pix;

  assign accept_evt = active && out_ready;
  assign row_end    = (col == wq - DIM_W'(1));
  assign last_pix   = row_end && (row == hq - DIM_W'(1));
  assign last_evt   = accept_evt && last_pix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      col    <= '0;
      row    <= '0;
      wq     <= '0;
      hq     <= '0;
      addr_q <= '0;
      step_q <= '0;
      pix_q  <= '0;
      done   <= 1'b0;
    end else begin
      done <= last_evt;
      if (start) begin
        active <= 1'b1;
        col    <= '0;
        row    <= '0;
        wq     <= start_w;
        hq     <= start_h;
        addr_q <= base;
        step_q <= row_step(pitch, bpp, start_w);
        pix_q  <= ADDR_W'(bpp);
      end else if (accept_evt) begin
        if (last_pix) begin
          active <= 1'b0;
        end else if (row_end) begin
          col    <= '0;
          row    <= row + DIM_W'(1);
          addr_q <= addr_q + pix_q + step_q;
        end else begin
          col    <= col + DIM_W'(1);
          addr_q <= addr_q + pix_q;
        end
      end
    end
  end

  assign out_valid = active;
  assign out_addr  = addr_q;
  assign busy      = active;
endmodule

// File: rtl/blit_addr_walker.sv
module blit_addr_walker
  import blitw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_en,
  input  logic [1:0]          reg_sel,
  input  logic [WORD_W-1:0]   reg_wdata,
  input  logic [BE_W-1:0]     reg_be,
  input  logic [PITCH_W-1:0]  pitch,
  input  logic [BPP_W-1:0]    bpp,
  output logic [ADDR_W-1:0]   dst_linear,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [ADDR_W-1:0]   out_addr,
  output logic                busy,
  output logic                done,
  output logic                err_size,
  output logic                wr_ignored
);
  logic [DIM_W-1:0] start_w, start_h;
  logic start_evt, convert_evt, accept_evt, last_evt;

  blitw_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .sel(reg_sel),
    .wdata(reg_wdata), .be(reg_be), .busy(busy), .pitch(pitch), .bpp(bpp),
    .start_w(start_w), .start_h(start_h), .dst_lin(dst_linear),
    .start_evt(start_evt), .convert_evt(convert_evt),
    .err_size(err_size), .wr_ignored(wr_ignored)
  );

  blitw_walker u_walk (
    .clk(clk), .rst_n(rst_n), .start(start_evt),
    .start_w(start_w), .start_h(start_h), .base(dst_linear),
    .pitch(pitch), .bpp(bpp), .out_ready(out_ready),
    .out_valid(out_valid), .out_addr(out_addr), .busy(busy), .done(done),
    .accept_evt(accept_evt), .last_evt(last_evt)
  );
endmodule

// File: rtl/blitw_chk.sv
module blitw_chk
  import blitw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic              start_evt,
  input logic              convert_evt,
  input logic              last_evt,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic              busy,
  input logic              done,
  input logic              err_size,
  input logic              wr_ignored
);
  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (busy && out_valid));

  assert_err_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_size |-> !busy);

  assert_no_convert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(convert_evt || start_evt));

  assert_valid_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

  assert_hold_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |=> (done && !busy));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ignore_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr_en) |=> wr_ignored);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ignored |=> wr_ignored);
endmodule

bind blit_addr_walker blitw_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en),
  .start_evt(start_evt), .convert_evt(convert_evt), .last_evt(last_evt),
  .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
  .busy(busy), .done(done), .err_size(err_size), .wr_ignored(wr_ignored)
);

// File: tb/tb_blit_addr_walker.sv
module tb_blit_addr_walker;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  // x, y, width, height, pitch, bpp, coordinate word used, ready mask
  localparam int VX[NV]  = '{0, 3, 2047, 5, 1};
  localparam int VY[NV]  = '{0, 2, 2047, 7, 0};
  localparam int VW[NV]  = '{1, 4, 3, 5, 2};
  localparam int VH[NV]  = '{1, 3, 2, 1, 2};
  localparam int VP[NV]  = '{64, 100, 8192, 320, 50};
  localparam int VB[NV]  = '{1, 2, 4, 3, 1};
  localparam int VS[NV]  = '{1, 2, 1, 2, 1};
  localparam int VM[NV]  = '{15, 5, 9, 14, 3};

  logic clk = 0, rst_n = 0;
  logic reg_wr_en = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic [3:0] reg_be = 0;
  logic [15:0] pitch = 16'd64;
  logic [2:0] bpp = 3'd1;
  logic out_ready = 0;
  logic [31:0] dst_linear, out_addr;
  logic out_valid, busy, done, err_size, wr_ignored;
  int n_chk = 0, n_bad = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blit_addr_walker dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .pitch(pitch), .bpp(bpp),
    .dst_linear(dst_linear), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .busy(busy), .done(done), .err_size(err_size),
    .wr_ignored(wr_ignored)
  );

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] b);
    reg_wr_en = 1; reg_sel = a; reg_wdata = d; reg_be = b;
    @(posedge clk); @(negedge clk);
    reg_wr_en = 0; reg_be = 0;
  endtask

  function automatic logic [31:0] cw(input int x, input int y);
    return {5'd0, 11'(y), 5'd0, 11'(x)};
  endfunction

  function automatic logic [31:0] sw(input int w, input int h);
    return {4'd0, 12'(h), 4'd0, 12'(w)};
  endfunction

  // walk a started job; entered on a falling edge
  task automatic collect(input longint base, input int w, input int h,
                         input int p, input int b, input int mask, input string req);
    int idx = 0;
    int cyc = 0;
    while (idx < w*h && cyc < 5000) begin
      out_ready = mask[cyc % 4];
      #1;
      if (out_valid && out_ready) begin
        longint e = base + longint'(idx / w) * p + longint'(idx % w) * b;
        chk(req, "pixel address", out_addr, e & 64'hFFFF_FFFF);
        idx++;
      end
      @(posedge clk); @(negedge clk);
      cyc++;
    end
    out_ready = 0;
    chk("R7", "done after last", done, 1);
    chk("R7", "busy after last", busy, 0);
    @(negedge clk);
    chk("R7", "done single pulse", done, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    longint base;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "busy", busy, 0);
    chk("R10", "out_valid", out_valid, 0);
    chk("R10", "done", done, 0);
    chk("R10", "err_size", err_size, 0);
    chk("R10", "wr_ignored", wr_ignored, 0);
    chk("R10", "dst_linear", dst_linear, 0);
    rst_n = 1;
    @(negedge clk);

    // table of jobs: R3/R4 conversion, R1 start, R5 walk
    for (int i = 0; i < NV; i++) begin
      pitch = 16'(VP[i]); bpp = 3'(VB[i]);
      wr(2'(VS[i]), cw(VX[i], VY[i]), 4'hF);
      base = longint'(VY[i]) * VP[i] + longint'(VX[i]) * VB[i];
      chk(VS[i] == 2 ? "R4" : "R3", "dst_linear", dst_linear, base);
      wr(2'd0, sw(VW[i], VH[i]), 4'hF);
      chk("R1", "busy after launch", busy, 1);
      chk("R1", "valid after launch", out_valid, 1);
      collect(base, VW[i], VH[i], VP[i], VB[i], VM[i], "R5");
    end

    // R9: size retained, byte 3 only relaunches 2x2 (pitch 50, bpp 1)
    base = dst_linear;
    wr(2'd0, 32'h0000_0000, 4'b1000);
    chk("R9", "busy on relaunch", busy, 1);
    collect(base, 2, 2, 50, 1, 6, "R9");

    // R3: low bytes only do not convert; top byte does
    pitch = 16'd10; bpp = 3'd2;
    wr(2'd1, cw(9, 0), 4'b0011);
    chk("R3", "no convert on low bytes", dst_linear, base);
    wr(2'd1, cw(0, 4), 4'b1100);
    chk("R3", "convert merged x and y", dst_linear, 4*10 + 9*2);
    // R4: word 3 has no effect
    wr(2'd3, 32'hFFFF_FFFF, 4'hF);
    chk("R4", "word 3 ignored busy", busy, 0);
    chk("R4", "word 3 ignored dst", dst_linear, 58);

    // R2: zero width, then zero height
    wr(2'd0, sw(0, 3), 4'hF);
    chk("R2", "err on zero width", err_size, 1);
    chk("R2", "no start zero width", busy, 0);
    @(negedge clk);
    chk("R2", "err pulse ends", err_size, 0);
    wr(2'd0, sw(3, 0), 4'hF);
    chk("R2", "err on zero height", err_size, 1);
    chk("R2", "no start zero height", out_valid, 0);

    // R8 and R6: writes during a stalled walk
    wr(2'd0, sw(3, 2), 4'hF);
    chk("R8", "flag before", wr_ignored, 0);
    base = 58;
    begin
      logic [31:0] held;
      held = out_addr;
      wr(2'd1, cw(100, 100), 4'hF);
      chk("R8", "flag set", wr_ignored, 1);
      chk("R6", "address held in stall", out_addr, held);
      wr(2'd0, sw(1, 1), 4'hF);
      @(negedge clk);
      chk("R6", "address still held", out_addr, held);
    end
    collect(base, 3, 2, 10, 2, 13, "R8");
    chk("R8", "coordinate write dropped", dst_linear, 58);
    chk("R8", "flag sticky", wr_ignored, 1);

    finish_run();
  end
endmodule